// File: doc/BRIEF.md
# Multiple-Register Stack Transfer Sequencer

This block executes a single push or pop of several general registers against a full-descending stack of 32-bit words. The caller pulses `start` with a 16-bit instruction word. The block takes the register set from the low byte of that word and the direction from the high byte. It then runs one word access per selected register over a request/ready memory port. Slots are assigned by register number: the lowest-numbered selected register always sits at the lowest address. The order in which the registers were listed when the word was encoded has no effect.

The block holds eight 32-bit general registers and a separate 32-bit stack pointer. A push reads the registers and writes memory. A pop reads memory and writes the registers. The stack pointer moves by four bytes per selected register when the transfer completes. A test port loads and reads the registers and loads the stack pointer, so the block can be used on its own.

Top module: `stkxfer_top`

## Requirements
- R1: Bit n of `instr[7:0]` selects register n. A legal operation performs exactly as many accepted memory beats as there are set bits in that byte.
- R2: Beats run in ascending register number. Each beat's address is the previous beat's address plus 4, so the lowest-numbered selected register uses the lowest address.
- R3: A push (`instr[15:8]` = 0xB4) starts at SP − 4·N, where N is the count of selected registers, and ends at SP − 4. After completion SP equals its old value − 4·N.
- R4: A pop (`instr[15:8]` = 0xBC) starts at SP and rises by 4 per beat. Each selected register is loaded with `mem_rdata` of its beat. After completion SP equals its old value + 4·N.
- R5: Any other value of `instr[15:8]` makes `illegal` and `done` high for the single cycle after `start`. No memory request is issued, `busy` stays low, and SP is unchanged.
- R6: A legal word with `instr[7:0]` = 0 raises `done` in the cycle after `start`. No request is issued, `busy` stays low, and SP and the registers are unchanged.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R8: For a legal non-empty word, `busy` is high from the cycle after `start` until the final beat is accepted, then low. `done` is high for exactly one cycle, the cycle after the final acceptance.
- R9: `start` and test-port loads are ignored while `busy` is high.
- R10: A stack pointer load from the test port clears bits 1:0, so SP and every stack address are word-aligned.
- R11: On a push beat `mem_we` is 1 and `mem_wdata` is the value of the register mapped to that slot. On a pop beat `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation using `instr` |
| instr | input | 16 | Instruction word: operation byte and register mask |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unknown operation byte |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken in the cycle `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts the current beat |
| tp_sp_load | input | 1 | Load SP from `tp_sp_val` |
| tp_sp_val | input | 32 | Stack pointer load value |
| tp_reg_we | input | 1 | Write register `tp_reg_sel` |
| tp_reg_sel | input | 3 | Register index for test write and read |
| tp_reg_wdata | input | 32 | Register write value |
| tp_reg_rdata | output | 32 | Value of register `tp_reg_sel` |
| sp_out | output | 32 | Current stack pointer |

## Verification
The case hardest to reach from the ports is a memory stall that falls in the middle of a sparse mask. The address must keep stepping by four while the register index jumps over cleared bits. The stimulus runs sparse masks such as 0xA5 while `mem_ready` follows a repeating stall pattern, so every position of the mask meets a held beat. A second start word is also pulsed mid-transfer, to show that it neither restarts nor disturbs the beat sequence.

// File: rtl/stkxfer_pkg.sv
package stkxfer_pkg;

  localparam int NREG  = 8;
  localparam int IDXW  = $clog2(NREG);
  localparam int CNTW  = $clog2(NREG + 1);
  localparam int WORDB = 4;

  localparam logic [7:0] OPB_PUSH = 8'hB4;
  localparam logic [7:0] OPB_POP  = 8'hBC;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_BAD  = 2'd2
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } st_e;

  // number of set bits in a register mask
  function automatic logic [CNTW-1:0] f_popcount(input logic [NREG-1:0] m);
    logic [CNTW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNTW'(m[i]);
    return c;
  endfunction

  // index of the lowest set bit (0 when the mask is empty)
  function automatic logic [IDXW-1:0] f_lowest(input logic [NREG-1:0] m);
    logic [IDXW-1:0] k;
    k = '0;
    for (int i = NREG - 1; i >= 0; i--) if (m[i]) k = IDXW'(i);
    return k;
  endfunction

  // byte span occupied by cnt words
  function automatic logic [31:0] f_span(input logic [CNTW-1:0] cnt);
    return 32'(cnt) * WORDB;
  endfunction

  // first address of the block
  function automatic logic [31:0] f_first_addr(input logic [31:0] sp,
                                               input logic [CNTW-1:0] cnt,
                                               input logic is_pop);
    return is_pop ? sp : sp - f_span(cnt);
  endfunction

  // stack pointer after the block completes
  function automatic logic [31:0] f_next_sp(input logic [31:0] sp,
                                            input logic [CNTW-1:0] cnt,
                                            input logic is_pop);
    return is_pop ? sp + f_span(cnt) : sp - f_span(cnt);
  endfunction

endpackage

// File: rtl/stkxfer_decode.sv
module stkxfer_decode
  import stkxfer_pkg::*;
(
  input  logic [15:0]           instr,
  output op_e                   op,
  output logic [NREG-1:0]       mask,
  output logic [CNTW-1:0]       cnt
);

  logic [7:0] opbyte;

  assign opbyte = instr[15:8];
  assign mask   = instr[NREG-1:0];
  assign cnt    = f_popcount(mask);

  always_comb begin
    unique case (opbyte)
      OPB_PUSH: op = OP_PUSH;
      OPB_POP:  op = OP_POP;
      default:  op = OP_BAD;
    endcase
  end

endmodule

// File: rtl/stkxfer_regs.sv
module stkxfer_regs
  import stkxfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  // sequencer side
  input  logic            seq_we,
  input  logic [IDXW-1:0] seq_idx,
  input  logic [DW-1:0]   seq_wdata,
  output logic [DW-1:0]   seq_rdata,
  input  logic            sp_upd,
  input  logic [31:0]     sp_new,
  output logic [31:0]     sp,
  // test port
  input  logic            tp_sp_load,
  input  logic [31:0]     tp_sp_val,
  input  logic            tp_reg_we,
  input  logic [IDXW-1:0] tp_reg_sel,
  input  logic [DW-1:0]   tp_reg_wdata,
  output logic [DW-1:0]   tp_reg_rdata
);

  logic [DW-1:0] gpr [NREG];
  logic [31:0]   sp_q;
  logic          tp_open;

  assign tp_open = !busy;

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    logic hit_seq, hit_tp;
    assign hit_seq = seq_we && (seq_idx == IDXW'(g));
    assign hit_tp  = tp_open && tp_reg_we && (tp_reg_sel == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       gpr[g] <= '0;
      else if (hit_seq) gpr[g] <= seq_wdata;
      else if (hit_tp)  gpr[g] <= tp_reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       sp_q <= '0;
    else if (sp_upd)                  sp_q <= {sp_new[31:2], 2'b00};
    else if (tp_open && tp_sp_load)   sp_q <= {tp_sp_val[31:2], 2'b00};
  end

  assign sp           = sp_q;
  assign seq_rdata    = gpr[seq_idx];
  assign tp_reg_rdata = gpr[tp_reg_sel];

  p_sp_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q[1:0] == 2'b00);

  p_tp_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sp_upd |=> $stable(sp_q));

endmodule

// File: rtl/stkxfer_seq.sv
module stkxfer_seq
  import stkxfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_e             dec_op,
  input  logic [NREG-1:0] dec_mask,
  input  logic [CNTW-1:0] dec_cnt,
  input  logic [31:0]     sp,
  output logic            sp_upd,
  output logic [31:0]     sp_new,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_idx,
  output logic [DW-1:0]   rf_wdata,
  input  logic [DW-1:0]   rf_rdata,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);

  st_e             st_q;
  logic [NREG-1:0] rem_q;
  logic [31:0]     addr_q;
  logic            pop_q;
  logic [CNTW-1:0] cnt_q;
  logic            done_q, ill_q;

  // named internal events
  logic            accept_go, accept_empty, accept_bad;
  logic            beat_acc, beat_last;
  logic [NREG-1:0] rem_nxt;

  assign accept_go    = start && (st_q == ST_IDLE) && (dec_op != OP_BAD) && (dec_cnt != '0);
  assign accept_empty = start && (st_q == ST_IDLE) && (dec_op != OP_BAD) && (dec_cnt == '0);
  assign accept_bad   = start && (st_q == ST_IDLE) && (dec_op == OP_BAD);

  assign rem_nxt   = rem_q & (rem_q - NREG'(1));
  assign beat_last = (rem_nxt == '0);
  assign beat_acc  = (st_q == ST_XFER) && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      pop_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (accept_bad) begin
        ill_q  <= 1'b1;
        done_q <= 1'b1;
      end else if (accept_empty) begin
        done_q <= 1'b1;
      end else if (accept_go) begin
        st_q   <= ST_XFER;
        rem_q  <= dec_mask;
        cnt_q  <= dec_cnt;
        pop_q  <= (dec_op == OP_POP);
        addr_q <= f_first_addr(sp, dec_cnt, dec_op == OP_POP);
      end else if (beat_acc) begin
        rem_q  <= rem_nxt;
        addr_q <= addr_q + WORDB;
        if (beat_last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rf_idx    = f_lowest(rem_q);
  assign rf_we     = beat_acc && pop_q;
  assign rf_wdata  = mem_rdata;
  assign sp_upd    = beat_acc && beat_last;
  assign sp_new    = f_next_sp(sp, cnt_q, pop_q);

  assign busy      = (st_q == ST_XFER);
  assign done      = done_q;
  assign illegal   = ill_q;
  assign mem_req   = busy;
  assign mem_we    = !pop_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_acc && !beat_last |=> mem_addr == $past(mem_addr) + 32'd4);

  p_push_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_acc && beat_last && !pop_q |-> mem_addr == sp - 32'd4);

  p_pop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_acc && beat_last && pop_q |-> mem_addr == sp + f_span(cnt_q) - 32'd4);

  p_no_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req && done);

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && dec_op != OP_BAD && dec_cnt != '0 |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && dec_op != OP_BAD && dec_cnt == '0 |=> done && !busy);

endmodule

// File: rtl/stkxfer_top.sv
module stkxfer_top
  import stkxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  input  logic        tp_sp_load,
  input  logic [31:0] tp_sp_val,
  input  logic        tp_reg_we,
  input  logic [2:0]  tp_reg_sel,
  input  logic [31:0] tp_reg_wdata,
  output logic [31:0] tp_reg_rdata,
  output logic [31:0] sp_out
);

  localparam int DW = 32;

  op_e             dec_op;
  logic [NREG-1:0] dec_mask;
  logic [CNTW-1:0] dec_cnt;
  logic            sp_upd, rf_we;
  logic [31:0]     sp_new, sp;
  logic [IDXW-1:0] rf_idx;
  logic [DW-1:0]   rf_wdata, rf_rdata;

  stkxfer_decode u_dec (
    .instr (instr),
    .op    (dec_op),
    .mask  (dec_mask),
    .cnt   (dec_cnt)
  );

  stkxfer_regs #(.DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .seq_we       (rf_we),
    .seq_idx      (rf_idx),
    .seq_wdata    (rf_wdata),
    .seq_rdata    (rf_rdata),
    .sp_upd       (sp_upd),
    .sp_new       (sp_new),
    .sp           (sp),
    .tp_sp_load   (tp_sp_load),
    .tp_sp_val    (tp_sp_val),
    .tp_reg_we    (tp_reg_we),
    .tp_reg_sel   (tp_reg_sel),
    .tp_reg_wdata (tp_reg_wdata),
    .tp_reg_rdata (tp_reg_rdata)
  );

  stkxfer_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dec_op    (dec_op),
    .dec_mask  (dec_mask),
    .dec_cnt   (dec_cnt),
    .sp        (sp),
    .sp_upd    (sp_upd),
    .sp_new    (sp_new),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .rf_wdata  (rf_wdata),
    .rf_rdata  (rf_rdata),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready)
  );

  assign sp_out = sp;

endmodule

// File: tb/sim_stkxfer_top.sv
`timescale 1ns/1ps
module sim_stkxfer_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, illegal, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic        tp_sp_load = 1'b0;
  logic [31:0] tp_sp_val = '0;
  logic        tp_reg_we = 1'b0;
  logic [2:0]  tp_reg_sel = '0;
  logic [31:0] tp_reg_wdata = '0;
  logic [31:0] tp_reg_rdata, sp_out;

  localparam logic [31:0] RKEY = 32'h5A5A_0000;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr ^ RKEY;

  stkxfer_top u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int beats   = 0;
  int cyc     = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;

  logic [31:0] exp_regs [8];
  logic [31:0] exp_sp;

  typedef struct packed { logic [31:0] addr; logic we; logic [31:0] wdata; } beat_t;
  beat_t sbq [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: drives ready, compares accepted beats against the scoreboard
  initial begin
    bit          held = 1'b0;
    beat_t       hb;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      if (held && mem_req) begin
        check(mem_addr == hb.addr, "R7 addr hold", mem_addr, hb.addr);
        check(mem_we == hb.we && mem_wdata == hb.wdata, "R7 data hold", mem_wdata, hb.wdata);
      end
      held = mem_req && !mem_ready;
      hb   = '{mem_addr, mem_we, mem_wdata};
      if (mem_req && mem_ready) begin
        beats++;
        if (sbq.size() == 0) begin
          check(1'b0, "R1 unexpected beat", mem_addr, 32'h0);
        end else begin
          beat_t e;
          e = sbq.pop_front();
          check(mem_addr == e.addr, "R2 beat address", mem_addr, e.addr);
          check(mem_we == e.we, "R11 beat direction", 32'(mem_we), 32'(e.we));
          if (e.we) check(mem_wdata == e.wdata, "R11 push data", mem_wdata, e.wdata);
        end
      end
    end
  end

  task automatic set_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    tp_reg_sel = 3'(i); tp_reg_wdata = v; tp_reg_we = 1'b1;
    @(negedge clk);
    tp_reg_we = 1'b0;
    exp_regs[i] = v;
  endtask

  task automatic load_sp(input logic [31:0] v);
    @(negedge clk);
    tp_sp_val = v; tp_sp_load = 1'b1;
    @(negedge clk);
    tp_sp_load = 1'b0;
    exp_sp = {v[31:2], 2'b00};
    check(sp_out == exp_sp, "R10 sp aligned load", sp_out, exp_sp);
  endtask

  // driver: computes expected beats, runs one operation, checks its outcome
  task automatic run_op(input logic [15:0] w, input logic [15:0] inject);
    int n; bit pop, legal; logic [31:0] base; int k; int waited;
    pop   = (w[15:8] == 8'hBC);
    legal = (w[15:8] == 8'hB4) || pop;
    n = 0;
    for (int i = 0; i < 8; i++) if (w[i]) n++;
    base = pop ? exp_sp : exp_sp - 32'(4 * n);
    k = 0;
    if (legal) begin
      for (int i = 0; i < 8; i++) if (w[i]) begin
        sbq.push_back('{base + 32'(4 * k), !pop, exp_regs[i]});
        k++;
      end
    end
    beats = 0;
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      check(illegal && done && !busy, "R5 illegal pulse", {29'd0, illegal, done, busy}, 32'h6);
    end else if (n == 0) begin
      check(done && !busy && !illegal, "R6 empty mask done", {29'd0, illegal, done, busy}, 32'h2);
    end else begin
      check(busy && !done, "R8 busy after start", {30'd0, done, busy}, 32'h1);
      waited = 0;
      while (!done && waited < 200) begin
        if (waited == 2 && inject != 16'h0) begin
          instr = inject; start = 1'b1;
          @(negedge clk);
          start = 1'b0; instr = w;
          waited++;
          continue;
        end
        @(negedge clk);
        waited++;
      end
      check(done && !busy, "R8 done with busy low", {30'd0, done, busy}, 32'h2);
      @(negedge clk);
      check(!done, "R8 done one cycle", 32'(done), 32'h0);
    end
    check(beats == n || (!legal && beats == 0), "R1 beat count", 32'(beats), legal ? 32'(n) : 32'h0);
    check(sbq.size() == 0, "R1 all beats seen", 32'(sbq.size()), 32'h0);
    sbq.delete();
    if (legal && n > 0) begin
      if (pop) begin
        exp_sp = exp_sp + 32'(4 * n);
        k = 0;
        for (int i = 0; i < 8; i++) if (w[i]) begin
          exp_regs[i] = (base + 32'(4 * k)) ^ RKEY;
          k++;
        end
      end else begin
        exp_sp = exp_sp - 32'(4 * n);
      end
    end
    check(sp_out == exp_sp, pop ? "R4 sp after pop" : "R3 sp after op", sp_out, exp_sp);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tp_reg_sel = 3'(i);
      #1;
      check(tp_reg_rdata == exp_regs[i], pop ? "R4 reg loaded" : "R6 reg unchanged", tp_reg_rdata, exp_regs[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !illegal && !mem_req, "R8 reset idle", {28'd0, busy, done, illegal, mem_req}, 32'h0);
    check(sp_out == 32'h0, "R10 reset sp", sp_out, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) set_reg(i, 32'h1000_0000 + 32'(i * 32'h111));
    load_sp(32'h2000_0103);
    run_op(16'hB407, 16'h0);          // R3: push R0..R2
    stall_mode = 1'b1;
    run_op(16'hB4A5, 16'h0);          // R2: sparse push with stalls
    run_op(16'hBC07, 16'h0);          // R4: pop three
    run_op(16'hB480, 16'h0);          // R3: single highest register
    run_op(16'hBCFF, 16'h0);          // R4: full-mask pop
    run_op(16'hB400, 16'h0);          // R6: empty push
    run_op(16'hBC00, 16'h0);          // R6: empty pop
    run_op(16'h1234, 16'h0);          // R5: unknown op
    run_op(16'hB507, 16'h0);          // R5: near-miss op byte
    run_op(16'hB4FF, 16'hBC01);       // R9: start ignored while busy
    run_op(16'hBC5A, 16'h0);          // R4: sparse pop with stalls
    // R9: test-port SP load while busy is ignored
    sbq.push_back('{exp_sp - 32'd4, 1'b1, exp_regs[3]});
    beats = 0;
    @(negedge clk); instr = 16'hB408; start = 1'b1;
    @(negedge clk); start = 1'b0; tp_sp_val = 32'h3000_0000; tp_sp_load = 1'b1;
    @(negedge clk); tp_sp_load = 1'b0;
    while (!done) @(negedge clk);
    exp_sp = exp_sp - 32'd4;
    @(negedge clk);
    check(sp_out == exp_sp, "R9 sp load ignored while busy", sp_out, exp_sp);
    check(sbq.size() == 0, "R1 single beat seen", 32'(sbq.size()), 32'h0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule